// File: doc/BRIEF.md
# Slow-Control Command Parser with Hardware Timing Commands

The block sits behind the low-rate serial control link from the host. It rebuilds bytes from the serial line, then assembles them into four-byte command frames. Each frame holds a start marker, an opcode, an argument and a check byte. Frames that carry a timing command are executed in logic after a fixed number of core cycles, with no software in the path. These commands can pulse one of the digital I/O lines, for example to fire a calibration LED; set all lines to a level pattern; or clear the timestamp register. Every other valid frame goes to the local processor through a byte-wide valid/ready port.

The latency of a timing command depends only on the serial timing and the `EXEC_DELAY` parameter. A stalled processor port, a full forward FIFO and handshakes in flight cannot move it. Frames with a bad check byte are dropped and counted in a saturating error counter.

Top module: `sc_cmd_parser`

## Requirements
- R1: The serial input idles high and carries 8N1 bytes, least significant bit first, with `CLKS_PER_BIT` core cycles per bit. A byte whose stop bit samples low is discarded.
- R2: A frame opens with the byte 0xA5, followed by opcode, argument and check byte. Bytes that arrive while no frame is open and that are not 0xA5 are ignored.
- R3: A frame is accepted only if its check byte equals opcode XOR argument. A failing frame has no other effect and raises `err_count` by one, saturating at all ones.
- R4: A local command (opcode 0x01 to 0x0F) takes effect on a fixed core clock edge, independent of `cpu_ready` and FIFO state. Counting the edge where the check byte's start bit is first present on `rx_serial` as edge 1, the edge is number CLKS_PER_BIT/2 + 9·CLKS_PER_BIT + EXEC_DELAY + 5.
- R5: Opcode 0x01 with argument n < NUM_IO drives `io_out[n]` high for exactly `cfg_pulse_len` cycles; the width is sampled when the command executes. An argument of NUM_IO or more has no effect.
- R6: `tstamp` rises by one every cycle. Opcode 0x02 sets it to 0 on the execution edge, and counting resumes from there.
- R7: Opcode 0x03 stores the low NUM_IO bits of its argument as a level mask. `io_out` is the mask OR the active pulses.
- R8: Opcodes 0x04 to 0x0F are accepted but change no output and are not forwarded.
- R9: Opcodes 0x00 and 0x10 to 0xFF are forwarded to the processor port as the three bytes opcode, argument, check byte, in that order. `cpu_data` holds while `cpu_valid` is high and `cpu_ready` is low.
- R10: Forwarded frames keep their order. A frame is dropped whole when fewer than three of the `FIFO_DEPTH` entries are free. The byte shown on the port does not count as an entry.
- R11: During reset `io_out`, `err_count`, `tstamp` and `cpu_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_serial | input | 1 | Serial command line, idle high |
| cfg_pulse_len | input | PLEN_W | Pulse width in cycles for opcode 0x01 |
| cpu_ready | input | 1 | Processor accepts the presented byte |
| io_out | output | NUM_IO | Digital I/O lines |
| tstamp | output | TS_W | Timestamp register |
| cpu_valid | output | 1 | A forwarded byte is presented |
| cpu_data | output | 8 | Forwarded byte |
| err_count | output | ERR_W | Saturating count of frames with a bad check byte |

## Verification
Two functions can land on the same cycle: a local command taking effect, and the processor port popping a forwarded byte. The bench parks two forwarded frames behind a low `cpu_ready`. It then sends a pulse command and starts toggling `cpu_ready` every cycle, beginning a few edges before the execution edge. Pops and the command's action therefore coincide. The run is judged on two points: the I/O edge must still fall on the exact cycle that R4 predicts, and the scoreboard must see every forwarded byte intact and in order.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [7:0] SOF_BYTE  = 8'hA5;
  localparam logic [7:0] OP_PULSE  = 8'h01;
  localparam logic [7:0] OP_TCLR   = 8'h02;
  localparam logic [7:0] OP_LEVEL  = 8'h03;
  localparam logic [7:0] LOCAL_MAX = 8'h0F;

  typedef struct packed {
    logic       vld;
    logic [7:0] op;
    logic [7:0] arg;
  } sc_cmd_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;
  typedef enum logic [1:0] {FR_HUNT, FR_OP, FR_ARG, FR_SUM} fr_st_e;
endpackage

// File: rtl/sc_bit_rx.sv
module sc_bit_rx import sc_pkg::*; #(
  parameter int CLKS_PER_BIT = 289
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx,
  output logic [7:0] byte_o,
  output logic       byte_vld
);
  localparam int CW   = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF = CLKS_PER_BIT / 2;

  logic          s1, s2;
  rx_st_e        st;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rx;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      byte_vld <= 1'b0;
      byte_o   <= '0;
      shreg    <= '0;
    end else begin
      byte_vld <= 1'b0;
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (!s2) st <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt     <= '0;
            bit_idx <= '0;
            st      <= s2 ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt     <= '0;
            shreg   <= {s2, shreg[7:1]};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) st <= RX_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            st  <= RX_IDLE;
            if (s2) begin
              byte_vld <= 1'b1;
              byte_o   <= shreg;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sc_frame_dec.sv
module sc_frame_dec import sc_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] byte_i,
  input  logic       byte_vld,
  output sc_cmd_t    cmd_o,
  output logic       fwd_vld,
  output logic [7:0] fwd_op,
  output logic [7:0] fwd_arg,
  output logic       bad_sum
);
  fr_st_e     st;
  logic [7:0] op_q, arg_q;
  logic       is_local;

  assign is_local = (op_q != 8'h00) && (op_q <= LOCAL_MAX);
  assign fwd_op   = op_q;
  assign fwd_arg  = arg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FR_HUNT;
      op_q    <= '0;
      arg_q   <= '0;
      cmd_o   <= '0;
      fwd_vld <= 1'b0;
      bad_sum <= 1'b0;
    end else begin
      cmd_o.vld <= 1'b0;
      fwd_vld   <= 1'b0;
      bad_sum   <= 1'b0;
      if (byte_vld) begin
        case (st)
          FR_HUNT: if (byte_i == SOF_BYTE) st <= FR_OP;
          FR_OP: begin
            op_q <= byte_i;
            st   <= FR_ARG;
          end
          FR_ARG: begin
            arg_q <= byte_i;
            st    <= FR_SUM;
          end
          default: begin
            st <= FR_HUNT;
            if (byte_i == (op_q ^ arg_q)) begin
              if (is_local) cmd_o <= '{vld: 1'b1, op: op_q, arg: arg_q};
              else          fwd_vld <= 1'b1;
            end else begin
              bad_sum <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sc_local_exec.sv
module sc_local_exec import sc_pkg::*; #(
  parameter int NUM_IO     = 8,
  parameter int EXEC_DELAY = 3,
  parameter int TS_W       = 32,
  parameter int PLEN_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  sc_cmd_t           cmd_i,
  input  logic [PLEN_W-1:0] pulse_len,
  output logic [NUM_IO-1:0] io_o,
  output logic [TS_W-1:0]   ts_o,
  output logic              fire_o
);
  sc_cmd_t           pipe [EXEC_DELAY];
  sc_cmd_t           cur;
  logic [NUM_IO-1:0] mask_q, mask_d, pulse_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < EXEC_DELAY; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= cmd_i;
      for (int i = 1; i < EXEC_DELAY; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign cur    = pipe[EXEC_DELAY-1];
  assign fire_o = cur.vld;

  for (genvar g = 0; g < NUM_IO; g++) begin : g_line
    logic [PLEN_W-1:0] cnt_q, cnt_d;
    always_comb begin
      cnt_d = cnt_q;
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      if (fire_o && cur.op == OP_PULSE && cur.arg == 8'(g)) cnt_d = pulse_len;
    end
    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
    end
    assign pulse_nxt[g] = (cnt_d != '0);
  end

  always_comb begin
    mask_d = mask_q;
    if (fire_o && cur.op == OP_LEVEL) mask_d = cur.arg[NUM_IO-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      io_o   <= '0;
      ts_o   <= '0;
    end else begin
      mask_q <= mask_d;
      io_o   <= mask_d | pulse_nxt;
      ts_o   <= (fire_o && cur.op == OP_TCLR) ? '0 : ts_o + 1'b1;
    end
  end
endmodule

// File: rtl/sc_fwd_fifo.sv
module sc_fwd_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] b0,
  input  logic [7:0] b1,
  input  logic [7:0] b2,
  input  logic       ready,
  output logic [7:0] data,
  output logic       valid
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [7:0]    hold [3];
  logic [1:0]    pend;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          wr, pop, room, take;

  assign room = (count <= (AW+1)'(DEPTH - 3));
  assign take = load && room && (pend == 2'd0);
  assign wr   = (pend != 2'd0);
  assign pop  = (count != '0) && (!valid || ready);

  always_ff @(posedge clk) begin
    if (take) begin
      hold[0] <= b0;
      hold[1] <= b1;
      hold[2] <= b2;
    end else if (wr) begin
      hold[0] <= hold[1];
      hold[1] <= hold[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      valid  <= 1'b0;
    end else begin
      if (take)    pend <= 2'd3;
      else if (wr) pend <= pend - 1'b1;
      if (wr)  wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(wr) - (AW+1)'(pop);
      if (pop)        valid <= 1'b1;
      else if (ready) valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr)  mem[wr_ptr] <= hold[0];
    if (pop) data <= mem[rd_ptr];
  end
endmodule

// File: rtl/sc_cmd_parser.sv
module sc_cmd_parser import sc_pkg::*; #(
  parameter int CLKS_PER_BIT = 289,
  parameter int NUM_IO       = 8,
  parameter int EXEC_DELAY   = 3,
  parameter int FIFO_DEPTH   = 16,
  parameter int ERR_W        = 8,
  parameter int TS_W         = 32,
  parameter int PLEN_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_serial,
  input  logic [PLEN_W-1:0] cfg_pulse_len,
  input  logic              cpu_ready,
  output logic [NUM_IO-1:0] io_out,
  output logic [TS_W-1:0]   tstamp,
  output logic              cpu_valid,
  output logic [7:0]        cpu_data,
  output logic [ERR_W-1:0]  err_count
);
  logic [7:0] rx_byte, fwd_op, fwd_arg;
  logic       rx_vld, fwd_vld, bad_sum, loc_vld, exec_fire;
  sc_cmd_t    loc_cmd;

  sc_bit_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst(rst), .rx(rx_serial), .byte_o(rx_byte), .byte_vld(rx_vld)
  );

  sc_frame_dec u_dec (
    .clk(clk), .rst(rst), .byte_i(rx_byte), .byte_vld(rx_vld), .cmd_o(loc_cmd),
    .fwd_vld(fwd_vld), .fwd_op(fwd_op), .fwd_arg(fwd_arg), .bad_sum(bad_sum)
  );

  assign loc_vld = loc_cmd.vld;

  sc_local_exec #(
    .NUM_IO(NUM_IO), .EXEC_DELAY(EXEC_DELAY), .TS_W(TS_W), .PLEN_W(PLEN_W)
  ) u_exec (
    .clk(clk), .rst(rst), .cmd_i(loc_cmd), .pulse_len(cfg_pulse_len),
    .io_o(io_out), .ts_o(tstamp), .fire_o(exec_fire)
  );

  sc_fwd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .load(fwd_vld), .b0(fwd_op), .b1(fwd_arg),
    .b2(fwd_op ^ fwd_arg), .ready(cpu_ready), .data(cpu_data), .valid(cpu_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)                          err_count <= '0;
    else if (bad_sum && ~&err_count)  err_count <= err_count + 1'b1;
  end
endmodule

// File: rtl/sc_cmd_parser_chk.sv
module sc_cmd_parser_chk #(
  parameter int EXEC_DELAY = 3,
  parameter int ERR_W      = 8,
  parameter int TS_W       = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             loc_vld,
  input logic             fire,
  input logic             cpu_valid,
  input logic             cpu_ready,
  input logic [7:0]       cpu_data,
  input logic [ERR_W-1:0] err_count,
  input logic [TS_W-1:0]  tstamp
);
  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst)                lat_cnt <= '0;
    else if (loc_vld)       lat_cnt <= 16'(EXEC_DELAY);
    else if (lat_cnt != '0) lat_cnt <= lat_cnt - 1'b1;
  end

  p_fixed_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (lat_cnt == 16'd1) |-> fire);
  p_no_stray_fire_r4: assert property (@(posedge clk) disable iff (rst)
    fire |-> (lat_cnt == 16'd1));
  p_hold_byte_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !cpu_ready) |=> (cpu_valid && $stable(cpu_data)));
  p_err_step_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1)));
  p_ts_step_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((tstamp == $past(tstamp) + 1'b1) || (tstamp == '0)));
endmodule

bind sc_cmd_parser sc_cmd_parser_chk #(
  .EXEC_DELAY(EXEC_DELAY), .ERR_W(ERR_W), .TS_W(TS_W)
) u_chk (
  .clk(clk), .rst(rst), .loc_vld(loc_vld), .fire(exec_fire),
  .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_data(cpu_data),
  .err_count(err_count), .tstamp(tstamp)
);

// File: tb/tb_sc_cmd_parser.sv
module tb_sc_cmd_parser;
  localparam int CPB   = 8;
  localparam int NIO   = 8;
  localparam int DLY   = 3;
  localparam int DEPTH = 8;
  localparam int EW    = 2;
  localparam int TW    = 16;
  localparam int PW    = 8;
  localparam int LAT   = 5 + CPB/2 + 9*CPB + DLY;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           rx_serial = 1'b1;
  logic [PW-1:0]  cfg_pulse_len = 8'd5;
  logic           cpu_ready = 1'b1;
  logic [NIO-1:0] io_out;
  logic [TW-1:0]  tstamp;
  logic           cpu_valid;
  logic [7:0]     cpu_data;
  logic [EW-1:0]  err_count;

  int   nchk = 0, nfail = 0, cyc = 0, last_start = 0;
  bit   toggle_en = 1'b0, done = 1'b0;
  logic [7:0] exp_q [$];

  sc_cmd_parser #(
    .CLKS_PER_BIT(CPB), .NUM_IO(NIO), .EXEC_DELAY(DLY), .FIFO_DEPTH(DEPTH),
    .ERR_W(EW), .TS_W(TW), .PLEN_W(PW)
  ) dut (
    .clk(clk), .rst(rst), .rx_serial(rx_serial), .cfg_pulse_len(cfg_pulse_len),
    .cpu_ready(cpu_ready), .io_out(io_out), .tstamp(tstamp),
    .cpu_valid(cpu_valid), .cpu_data(cpu_data), .err_count(err_count)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // scoreboard monitor: pops one expected byte per handshake
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && cpu_valid && cpu_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected byte", cpu_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(cpu_data == e, "R9 forwarded byte", cpu_data, e);
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (toggle_en) cpu_ready = ~cpu_ready;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected done", cyc);
    finish_run();
  end

  task automatic send_byte(input logic [7:0] b, input bit stop_ok = 1'b1);
    @(negedge clk);
    rx_serial = 1'b0;
    last_start = cyc;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_serial = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx_serial = stop_ok;
    repeat (CPB) @(negedge clk);
    rx_serial = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] op, input logic [7:0] arg, input bit corrupt = 1'b0);
    send_byte(8'hA5);
    send_byte(op);
    send_byte(arg);
    send_byte((op ^ arg) ^ (corrupt ? 8'h01 : 8'h00));
  endtask

  task automatic fwd_frame(input logic [7:0] op, input logic [7:0] arg);
    exp_q.push_back(op);
    exp_q.push_back(arg);
    exp_q.push_back(op ^ arg);
    send_frame(op, arg);
  endtask

  task automatic wait_io(input logic [NIO-1:0] exp, input string req);
    logic [NIO-1:0] prev;
    int n;
    prev = io_out;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (io_out == prev && n < 400);
    check(io_out == exp, req, io_out, exp);
    check(cyc - last_start == LAT, "R4 execution cycle", cyc - last_start, LAT);
  endtask

  task automatic quiet(input int n, input logic [NIO-1:0] exp, input string req);
    bit moved;
    moved = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (io_out != exp) moved = 1'b1;
    end
    check(!moved && io_out == exp, req, io_out, exp);
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    int w;
    repeat (5) @(negedge clk);
    // R11: reset state
    check(io_out == '0, "R11 io_out", io_out, 0);
    check(err_count == '0, "R11 err_count", err_count, 0);
    check(tstamp == '0, "R11 tstamp", tstamp, 0);
    check(cpu_valid == 1'b0, "R11 cpu_valid", cpu_valid, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    // R7: level mask
    send_frame(8'h03, 8'h0F);
    wait_io(8'h0F, "R7 level mask");

    // R5: pulse on line 7 combined with the mask
    cfg_pulse_len = 8'd5;
    send_frame(8'h01, 8'h07);
    wait_io(8'h8F, "R5 pulse rise");
    w = 0;
    while (io_out[7]) begin
      w++;
      @(negedge clk);
    end
    check(w == 5, "R5 pulse width", w, 5);
    check(io_out == 8'h0F, "R7 mask after pulse", io_out, 8'h0F);

    // R5: argument out of range
    send_frame(8'h01, 8'h09);
    quiet(LAT, 8'h0F, "R5 out-of-range line");

    // R6: time register clear
    send_frame(8'h02, 8'h00);
    wait_cyc(last_start + LAT - 1);
    check(tstamp != '0, "R6 before clear", tstamp, 1);
    @(negedge clk);
    check(tstamp == '0, "R6 cleared", tstamp, 0);
    @(negedge clk);
    check(tstamp == 16'd1, "R6 counting resumes", tstamp, 1);

    // R8: reserved local opcodes
    send_frame(8'h05, 8'hFF);
    send_frame(8'h0F, 8'h00);
    quiet(LAT, 8'h0F, "R8 no io effect");
    check(cpu_valid == 1'b0, "R8 nothing forwarded", cpu_valid, 0);

    // R9: forwarding with ready high
    fwd_frame(8'h20, 8'h5A);
    fwd_frame(8'h00, 8'h11);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R9 all forwarded", exp_q.size(), 0);

    // R3: bad check byte
    send_frame(8'h03, 8'hFF, 1'b1);
    quiet(LAT, 8'h0F, "R3 bad frame ignored");
    check(err_count == 2'd1, "R3 error count", err_count, 1);

    // R2: stray bytes while hunting
    send_byte(8'h03);
    send_byte(8'hFF);
    send_byte(8'hFC);
    quiet(LAT, 8'h0F, "R2 stray bytes");
    send_frame(8'h03, 8'h33);
    wait_io(8'h33, "R2 frame after stray bytes");

    // R1: start marker with a low stop bit is dropped
    send_byte(8'hA5, 1'b0);
    repeat (2*CPB) @(negedge clk);
    send_byte(8'h03);
    send_byte(8'h00);
    send_byte(8'h03);
    quiet(LAT, 8'h33, "R1 bad stop bit");
    check(err_count == 2'd1, "R1 no error counted", err_count, 1);

    // R10: overflow while the processor stalls
    cpu_ready = 1'b0;
    fwd_frame(8'h40, 8'h01);
    fwd_frame(8'h41, 8'h02);
    fwd_frame(8'h42, 8'h03);
    send_frame(8'h43, 8'h04);
    repeat (20) @(negedge clk);
    check(cpu_valid == 1'b1, "R9 byte held", cpu_valid, 1);
    cpu_ready = 1'b1;
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R10 three frames kept", exp_q.size(), 0);
    fwd_frame(8'h44, 8'h05);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R10 frame after drain", exp_q.size(), 0);

    // R4 with R9: execution edge coincides with handshakes
    cpu_ready = 1'b0;
    fwd_frame(8'h50, 8'hAA);
    fwd_frame(8'h51, 8'hBB);
    cfg_pulse_len = 8'd3;
    send_frame(8'h01, 8'h02);
    wait_cyc(last_start + LAT - 3);
    toggle_en = 1'b1;
    wait_io(8'h37, "R4 pulse during handshakes");
    repeat (3) @(negedge clk);
    check(io_out == 8'h33, "R5 short pulse ended", io_out, 8'h33);
    toggle_en = 1'b0;
    @(negedge clk);
    cpu_ready = 1'b1;
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R10 order under collision", exp_q.size(), 0);

    // R3: saturation
    send_frame(8'h03, 8'h00, 1'b1);
    repeat (10) @(negedge clk);
    check(err_count == 2'd2, "R3 second error", err_count, 2);
    send_frame(8'h03, 8'h00, 1'b1);
    send_frame(8'h03, 8'h00, 1'b1);
    repeat (10) @(negedge clk);
    check(err_count == 2'd3, "R3 saturated", err_count, 3);
    check(io_out == 8'h33, "R3 io untouched", io_out, 8'h33);

    finish_run();
  end
endmodule